// File: doc/BRIEF.md
# Platform Sleep State Sequencer

This block tracks the host chipset's active-low sleep requests and a core power-good input, and walks a power state machine through the off, soft-off, suspend-to-RAM, running and low-power-idle states. Every move between two stable states passes through a transitional state that lasts one cycle. The side effects of the move happen in that state: backlight control, thermal throttle, one-cycle event strobes for the surrounding firmware logic, and the forced-shutdown button emulation.

The machine also forwards the chipset's suspend-well request to the power controller, except when the machine is heading down to off. It passes the resume-reset power-good through to the chipset with a delay on release. The charger gate holds the power-up sequence until a charger-ready flag arrives. The gate polls that flag a bounded number of times and gives up if it never comes. All delays are cycle-count parameters.

Top module: `sleep_seq`

## Requirements
- R1: After reset the state output reads 0 (off). Backlight, throttle, button press, the power-controller suspend line, resume-reset and all event strobes are low.
- R2: In the off state, a power-on request moves the machine to the charger-wait state (1). With charger ready, shutdown not wanted and `slp_sus_n` high, the next cycle enters soft-off (2).
- R3: The state encoding is 0 off, 1 charger-wait, 2 soft-off, 3 soft-off to suspend, 4 suspend, 5 suspend to run, 6 run, 7 run to suspend, 8 run to idle, 9 idle, 10 idle to run, 11 suspend to soft-off, 12 soft-off to off. Soft-off leaves on `slp_s4_n` high. Suspend goes up on `slp_s3_n` high and down on `slp_s4_n` low. Run goes down on `slp_s3_n` low. Every transitional state lasts one cycle.
- R4: Run enters idle through state 8 when `slp_s0_n` is low and `slp_s3_n` is high. Idle returns through state 10 when both are high.
- R5: Loss of `core_pg` forces a shutdown, which raises `pwrbtn_press` unless the machine is in off. The machine then moves down one level: run goes to 7, suspend and suspend-to-run go to 11, and soft-off-to-suspend goes to 12.
- R6: `pwrbtn_press` falls at the clock edge where the machine enters soft-off.
- R7: In charger-wait, a high `shdn_want` forces a shutdown and returns to off. The same happens after RETRY_MAX polls of POLL_CYC cycles each without charger ready.
- R8: `bl_en` rises on leaving state 5 for run and falls on leaving state 7.
- R9: `prochot` takes `throttle_req` only on leaving state 5 and while in run. In other states it holds its value.
- R10: `pmic_sus_n` copies `slp_sus_n` each cycle unless the next state is 0 or 12. It is driven low on leaving state 12.
- R11: `rsmrst_n` falls the cycle after `rsm_pg` falls. It rises only after `rsm_pg` has been high for RSM_DLY consecutive cycles.
- R12: Each event strobe is high for one cycle, in the first cycle of the state that follows its transitional state. `ev_startup` follows state 3, `ev_resume` follows 5 or 10, `ev_suspend` follows 7 or 8, and `ev_shutdown` follows 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on_req | input | 1 | Request to leave the off state |
| slp_s0_n | input | 1 | Chipset idle request, active low |
| slp_s3_n | input | 1 | Chipset suspend request, active low |
| slp_s4_n | input | 1 | Chipset soft-off request, active low |
| slp_sus_n | input | 1 | Chipset suspend-well request, active low |
| core_pg | input | 1 | Core rail power-good |
| chg_ready | input | 1 | Charger allows power-on |
| shdn_want | input | 1 | Charger demands shutdown |
| throttle_req | input | 1 | CPU throttle request |
| rsm_pg | input | 1 | Resume-well power-good |
| state_o | output | 4 | Current state code |
| bl_en | output | 1 | Backlight enable |
| prochot | output | 1 | CPU throttle output |
| pmic_sus_n | output | 1 | Suspend-well request to power controller |
| pwrbtn_press | output | 1 | Emulated power-button press |
| rsmrst_n | output | 1 | Resume reset to chipset |
| ev_startup | output | 1 | Startup event strobe |
| ev_resume | output | 1 | Resume event strobe |
| ev_suspend | output | 1 | Suspend event strobe |
| ev_shutdown | output | 1 | Shutdown event strobe |

## Verification
The hardest case to reach is the release of the emulated button press. The press must first be latched by a forced shutdown: either an exhausted charger wait or a power-good loss in run. It must then stay held through off until a later power-up reaches soft-off. The stimulus starts with a retry exhaustion using small poll parameters, which latches the press while still in off. A normal power-up then follows. Later in the run, power-good is dropped in run and the walk goes through suspend and soft-off down to off. This shows the press released at soft-off and the suspend line forced low on the way down.

// File: rtl/sleep_seq.sv
module sleep_seq #(
  parameter int RETRY_MAX = 40,
  parameter int POLL_CYC  = 100000,
  parameter int RSM_DLY   = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_req,
  input  logic       slp_s0_n,
  input  logic       slp_s3_n,
  input  logic       slp_s4_n,
  input  logic       slp_sus_n,
  input  logic       core_pg,
  input  logic       chg_ready,
  input  logic       shdn_want,
  input  logic       throttle_req,
  input  logic       rsm_pg,
  output logic [3:0] state_o,
  output logic       bl_en,
  output logic       prochot,
  output logic       pmic_sus_n,
  output logic       pwrbtn_press,
  output logic       rsmrst_n,
  output logic       ev_startup,
  output logic       ev_resume,
  output logic       ev_suspend,
  output logic       ev_shutdown
);
  localparam int PW = $clog2(POLL_CYC + 1);
  localparam int TW = $clog2(RETRY_MAX + 1);
  localparam int RW = $clog2(RSM_DLY + 1);

  typedef enum logic [3:0] {
    OFF = 4'd0, CHG = 4'd1, SOFT = 4'd2, SF_SU = 4'd3, SUSP = 4'd4, SU_RUN = 4'd5,
    RUN = 4'd6, RUN_SU = 4'd7, RUN_ID = 4'd8, IDLE = 4'd9, ID_RUN = 4'd10,
    SU_SF = 4'd11, SF_OFF = 4'd12
  } st_t;

  st_t state, nxt;
  logic force_sd;
  logic [PW-1:0] poll_cnt;
  logic [TW-1:0] tries;
  logic [RW-1:0] rsm_cnt;
  wire poll_end = (poll_cnt == PW'(POLL_CYC - 1));
  wire exhausted = !chg_ready && poll_end && (tries == TW'(RETRY_MAX - 1));

  assign state_o = state;

  always_comb begin
    nxt = state;
    force_sd = 1'b0;
    case (state)
      OFF:    if (pwr_on_req) nxt = CHG;
      CHG:
        if (shdn_want || exhausted) begin
          force_sd = 1'b1;
          nxt = OFF;
        end else if (chg_ready && slp_sus_n) nxt = SOFT;
      SOFT:   if (slp_s4_n) nxt = SF_SU;
      SF_SU:
        if (!core_pg) begin
          force_sd = 1'b1;
          nxt = SF_OFF;
        end else nxt = SUSP;
      SUSP:
        if (!core_pg) begin
          force_sd = 1'b1;
          nxt = SU_SF;
        end else if (slp_s3_n) nxt = SU_RUN;
        else if (!slp_s4_n) nxt = SU_SF;
      SU_RUN:
        if (!core_pg) begin
          force_sd = 1'b1;
          nxt = SU_SF;
        end else nxt = RUN;
      RUN:
        if (!core_pg) begin
          force_sd = 1'b1;
          nxt = RUN_SU;
        end else if (!slp_s0_n && slp_s3_n) nxt = RUN_ID;
        else if (!slp_s3_n) nxt = RUN_SU;
      RUN_SU: nxt = SUSP;
      RUN_ID: nxt = IDLE;
      IDLE:   if (slp_s0_n && slp_s3_n) nxt = ID_RUN;
      ID_RUN: nxt = RUN;
      SU_SF:  nxt = SOFT;
      SF_OFF: nxt = OFF;
      default: nxt = OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= OFF;
      poll_cnt     <= '0;
      tries        <= '0;
      pwrbtn_press <= 1'b0;
      bl_en        <= 1'b0;
      prochot      <= 1'b0;
      pmic_sus_n   <= 1'b0;
      ev_startup   <= 1'b0;
      ev_resume    <= 1'b0;
      ev_suspend   <= 1'b0;
      ev_shutdown  <= 1'b0;
    end else begin
      state <= nxt;

      if (state != CHG) begin
        poll_cnt <= '0;
        tries    <= '0;
      end else if (!chg_ready) begin
        if (poll_end) begin
          poll_cnt <= '0;
          tries    <= tries + 1'b1;
        end else poll_cnt <= poll_cnt + 1'b1;
      end

      if (force_sd && state != OFF) pwrbtn_press <= 1'b1;
      else if (nxt == SOFT && state != SOFT) pwrbtn_press <= 1'b0;

      if (state == SU_RUN && core_pg) bl_en <= 1'b1;
      else if (state == RUN_SU) bl_en <= 1'b0;

      if ((state == SU_RUN && core_pg) || state == RUN) prochot <= throttle_req;

      if (state == SF_OFF) pmic_sus_n <= 1'b0;
      else if (nxt != OFF && nxt != SF_OFF) pmic_sus_n <= slp_sus_n;

      ev_startup  <= state == SF_SU && core_pg;
      ev_resume   <= (state == SU_RUN && core_pg) || state == ID_RUN;
      ev_suspend  <= state == RUN_SU || state == RUN_ID;
      ev_shutdown <= state == SU_SF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsmrst_n <= 1'b0;
      rsm_cnt  <= '0;
    end else if (!rsm_pg) begin
      rsmrst_n <= 1'b0;
      rsm_cnt  <= '0;
    end else if (!rsmrst_n) begin
      if (rsm_cnt == RW'(RSM_DLY - 1)) rsmrst_n <= 1'b1;
      else rsm_cnt <= rsm_cnt + 1'b1;
    end
  end

  // R3
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 4'd12);
  // R3
  down_to_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 4'd11 |=> state_o == 4'd2);
  // R5
  press_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrbtn_press) |-> $past(state_o) != 4'd0);
  // R6
  press_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwrbtn_press) |-> state_o == 4'd2);
  // R8
  bl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bl_en) |-> $past(state_o) == 4'd5);
  // R10
  sus_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 4'd12 |=> (state_o == 4'd0 && !pmic_sus_n));
  // R11
  rsm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsm_pg |=> !rsmrst_n);
  // R12
  ev_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_startup, ev_resume, ev_suspend, ev_shutdown}));
endmodule

// File: tb/sim_sleep_seq.sv
module sim_sleep_seq;
  localparam int CLK_PER = 10;
  localparam int RETRY = 3;
  localparam int POLL = 4;
  localparam int RDLY = 5;

  logic clk = 0, rst_n = 0;
  logic pwr_on_req = 0, slp_s0_n = 0, slp_s3_n = 0, slp_s4_n = 0, slp_sus_n = 0;
  logic core_pg = 1, chg_ready = 1, shdn_want = 0, throttle_req = 0, rsm_pg = 0;
  logic [3:0] state_o;
  logic bl_en, prochot, pmic_sus_n, pwrbtn_press, rsmrst_n;
  logic ev_startup, ev_resume, ev_suspend, ev_shutdown;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  sleep_seq #(.RETRY_MAX(RETRY), .POLL_CYC(POLL), .RSM_DLY(RDLY)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .slp_s0_n(slp_s0_n),
    .slp_s3_n(slp_s3_n), .slp_s4_n(slp_s4_n), .slp_sus_n(slp_sus_n),
    .core_pg(core_pg), .chg_ready(chg_ready), .shdn_want(shdn_want),
    .throttle_req(throttle_req), .rsm_pg(rsm_pg), .state_o(state_o),
    .bl_en(bl_en), .prochot(prochot), .pmic_sus_n(pmic_sus_n),
    .pwrbtn_press(pwrbtn_press), .rsmrst_n(rsmrst_n), .ev_startup(ev_startup),
    .ev_resume(ev_resume), .ev_suspend(ev_suspend), .ev_shutdown(ev_shutdown));

  // {s0,s3,s4,sus,pg} inputs, expected state, expected {startup,resume,suspend,shutdown}
  localparam logic [12:0] VEC [12] = '{
    {5'b10111, 4'd3,  4'b0000}, {5'b10111, 4'd4,  4'b1000},
    {5'b11111, 4'd5,  4'b0000}, {5'b11111, 4'd6,  4'b0100},
    {5'b01111, 4'd8,  4'b0000}, {5'b01111, 4'd9,  4'b0010},
    {5'b11111, 4'd10, 4'b0000}, {5'b11111, 4'd6,  4'b0100},
    {5'b10111, 4'd7,  4'b0000}, {5'b10111, 4'd4,  4'b0010},
    {5'b10011, 4'd11, 4'b0000}, {5'b10011, 4'd2,  4'b0001}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R1
    chk("R1 state", state_o, 0);
    chk("R1 outputs", {bl_en, prochot, pmic_sus_n, pwrbtn_press, rsmrst_n}, 0);
    chk("R1 events", {ev_startup, ev_resume, ev_suspend, ev_shutdown}, 0);

    // R7 retry exhaustion
    chg_ready = 0; slp_sus_n = 1; pwr_on_req = 1;
    step(); pwr_on_req = 0;
    chk("R2 enter charger wait", state_o, 1);
    step(RETRY*POLL - 1);
    chk("R7 still waiting", state_o, 1);
    step();
    chk("R7 exhausted to off", state_o, 0);
    chk("R5 press latched", pwrbtn_press, 1);

    // R7 shutdown wanted
    chg_ready = 1; shdn_want = 1; pwr_on_req = 1;
    step(); pwr_on_req = 0;
    step();
    chk("R7 shdn_want to off", state_o, 0);
    shdn_want = 0;

    // R2 normal power-up
    pwr_on_req = 1;
    step(); pwr_on_req = 0;
    step();
    chk("R2 soft-off", state_o, 2);
    chk("R6 press released", pwrbtn_press, 0);
    chk("R10 mirror high", pmic_sus_n, 1);

    // R3 R4 R12 table walk
    foreach (VEC[i]) begin
      {slp_s0_n, slp_s3_n, slp_s4_n, slp_sus_n, core_pg} = VEC[i][12:8];
      step();
      chk("R3/R4 state", state_o, VEC[i][7:4]);
      chk("R12 events", {ev_startup, ev_resume, ev_suspend, ev_shutdown}, VEC[i][3:0]);
    end

    // R10 mirror in soft-off
    slp_sus_n = 0; step();
    chk("R10 mirror low", pmic_sus_n, 0);
    slp_sus_n = 1; step();
    chk("R10 mirror back", pmic_sus_n, 1);

    // R8 R9
    throttle_req = 1; slp_s4_n = 1;
    step(2);
    chk("R3 suspend", state_o, 4);
    chk("R9 no throttle outside run", prochot, 0);
    slp_s3_n = 1;
    step(2);
    chk("R3 run", state_o, 6);
    chk("R8 backlight on", bl_en, 1);
    chk("R9 throttle at resume", prochot, 1);
    throttle_req = 0; step();
    chk("R9 throttle follows", prochot, 0);

    // R5 R6 R10 power-good loss
    core_pg = 0; step();
    chk("R5 run to 7", state_o, 7);
    chk("R5 press", pwrbtn_press, 1);
    step();
    chk("R8 backlight off", bl_en, 0);
    step();
    chk("R5 suspend to 11", state_o, 11);
    step();
    chk("R6 soft-off", state_o, 2);
    chk("R6 press released at soft-off", pwrbtn_press, 0);
    step();
    chk("R3 soft-off to suspend", state_o, 3);
    step();
    chk("R5 to 12", state_o, 12);
    chk("R5 press again", pwrbtn_press, 1);
    step();
    chk("R10 off", state_o, 0);
    chk("R10 suspend line low", pmic_sus_n, 0);

    // R11
    rsm_pg = 1;
    step(RDLY - 1);
    chk("R11 held", rsmrst_n, 0);
    step();
    chk("R11 released", rsmrst_n, 1);
    rsm_pg = 0; step();
    chk("R11 immediate drop", rsmrst_n, 0);

    finish_run();
  end
endmodule